// File: doc/BRIEF.md
# Per-Slave Grant Arbiter with Parking

This block decides which of up to sixteen bus masters owns one slave port of a multi-layer interconnect. Every cycle it looks at the masters' request lines and a flag that says whether the owning master's burst continues. It keeps the slave bound to one master for as long as that burst lasts. When the transfer ends it picks the next owner, either by rotating fairness or by programmed priority values.

When nobody is asking for the slave, the block leaves it connected to a speculative "parked" owner. The parking policy decides which owner that is: nobody, the master that was served last, or a programmed master index. A master that finds the slave already connected to it is served in the same cycle. Any other master first spends one cycle waiting while the connection is switched over, and the block flags that cycle on a latency output. Address decoding, data steering and configuration registers belong to the surrounding interconnect; this block only takes their settings as plain inputs.

Top module: `slv_grant_arbiter`

## Requirements
- R1: `grant` is always one-hot or all zero. `grant_vld` is high exactly when the connected master's request bit is high.
- R2: A requesting master that is already connected is served in the same cycle: `grant_vld` is high and `wait_lat` is low.
- R3: When a request is pending and no requester is connected, `wait_lat` is high for that cycle. On the next cycle a requesting master is connected.
- R4: While `grant_vld` and `burst_busy` are both high, `grant` does not change on the next cycle, whatever the other requests do.
- R5: With `arb_mode` = 0 (rotating), the search for the next owner starts at the master after the last one chosen by arbitration and wraps from the top index to 0. After reset the search starts at master 0.
- R6: With `arb_mode` = 1 (priority), the requester with the largest 4-bit value wins, where master i's value is held in `prio[4*i+3:4*i]`. On equal values the lowest index wins.
- R7: With `park_mode` = 0, or the reserved code 3, the slave is released (`grant` = 0) on the cycle after a cycle with no requests.
- R8: With `park_mode` = 1, the cycle after a cycle with no requests keeps `grant` unchanged, so the slave stays with the last owner.
- R9: With `park_mode` = 2, the cycle after a cycle with no requests shows `grant` equal to one-hot of `park_idx`.
- R10: On reset, `grant` becomes one-hot of `park_idx` when `park_mode` = 2, and all zero otherwise.
- R11: Arbitration uses the requests of the current cycle, and its result appears on `grant` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_MST | Request line of each master |
| burst_busy | input | 1 | The connected master's transfer continues next cycle |
| arb_mode | input | 1 | 0 rotating, 1 priority values |
| park_mode | input | 2 | 0 none, 1 last owner, 2 fixed index, 3 treated as none |
| park_idx | input | $clog2(N_MST) | Master used for fixed parking |
| prio | input | N_MST*PRIO_W | Packed per-master priority values, master 0 in the low bits |
| grant | output | N_MST | One-hot connected master, or zero |
| grant_vld | output | 1 | The connected master is transferring this cycle |
| wait_lat | output | 1 | A request is paying the one-cycle switch latency |

## Verification
Two situations put functions of this block in the same cycle. In the first, the parked owner's burst is still running when a competing request arrives, so the burst hold and arbitration meet. The bench drives that case directly and expects the owner to stay put until `burst_busy` drops, with the competitor taking over one cycle later. In the second, the last request drops on the same edge that parking is decided. The bench ends requests under every `park_mode` code, including the reserved one, and a cycle-level reference model kept in the bench judges every cycle against R1 to R11. A long random phase then mixes requests, burst flags, both arbitration modes and all parking codes, so that these meetings happen under many orderings.

// File: rtl/slv_arb_pkg.sv
// Package: shared encodings for the per-slave grant arbiter.
// Assumes: configuration inputs carry these codes as plain vectors.
package slv_arb_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_e;

    typedef enum logic {
        ARB_ROTATE = 1'b0,
        ARB_PRIO   = 1'b1
    } arb_e;

endpackage

// File: rtl/slv_rr_pick.sv
// Module: rotating picker. Finds the first requester strictly after
// last_idx, wrapping from the top index back to zero.
// Assumes: last_idx < N_MST; found is low when req is all zero.
module slv_rr_pick #(
    parameter int N_MST = 16,
    parameter int IDX_W = $clog2(N_MST)
) (
    input  logic [N_MST-1:0] req,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] win_idx,
    output logic             found
);

    // Purpose: scan N_MST positions after last_idx and keep the first hit.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= N_MST; k++) begin
            int pos;
            pos = (int'(last_idx) + k) % N_MST;
            if (!found && req[pos]) begin
                found   = 1'b1;
                win_idx = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/slv_prio_pick.sv
// Module: priority picker. Chooses the requester with the largest
// priority value; on a tie the lowest index wins.
// Assumes: prio packs master i's value at bits [i*PRIO_W +: PRIO_W].
module slv_prio_pick #(
    parameter int N_MST  = 16,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N_MST)
) (
    input  logic [N_MST-1:0]        req,
    input  logic [N_MST*PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]        win_idx,
    output logic                    found
);

    logic [PRIO_W-1:0] best;

    // Purpose: walk upward and replace the candidate only on a strictly larger value.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (req[i] && (!found || prio[i*PRIO_W +: PRIO_W] > best)) begin
                found   = 1'b1;
                best    = prio[i*PRIO_W +: PRIO_W];
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/slv_grant_arbiter.sv
// Module: per-slave grant arbiter with speculative parking.
// Holds one registered connection. The connected master is served in
// the cycle it requests; any other requester waits one cycle while
// the connection is switched. The connection is held through a burst
// and re-arbitrated only when the transfer ends. When there are no
// requests it parks according to park_mode.
// Assumes: configuration inputs are quasi-static; synchronous active-low reset.
module slv_grant_arbiter
    import slv_arb_pkg::*;
#(
    parameter int N_MST  = 16,
    parameter int PRIO_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_MST-1:0]          req,
    input  logic                      burst_busy,
    input  logic                      arb_mode,
    input  logic [1:0]                park_mode,
    input  logic [$clog2(N_MST)-1:0]  park_idx,
    input  logic [N_MST*PRIO_W-1:0]   prio,
    output logic [N_MST-1:0]          grant,
    output logic                      grant_vld,
    output logic                      wait_lat
);

    localparam int IDX_W = $clog2(N_MST);

    logic             conn_on;
    logic [IDX_W-1:0] conn_idx;
    logic [IDX_W-1:0] rr_last;
    logic [IDX_W-1:0] rr_win;
    logic [IDX_W-1:0] pr_win;
    logic [IDX_W-1:0] arb_win;
    logic             rr_found;
    logic             pr_found;
    logic             req_any;
    logic             hold;
    park_e            park_sel;
    arb_e             arb_sel;

    slv_rr_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_rr (
        .req      (req),
        .last_idx (rr_last),
        .win_idx  (rr_win),
        .found    (rr_found)
    );

    slv_prio_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_prio (
        .req     (req),
        .prio    (prio),
        .win_idx (pr_win),
        .found   (pr_found)
    );

    // Purpose: decode configuration and pick the winner of the selected scheme.
    always_comb begin
        park_sel = park_e'(park_mode);
        arb_sel  = arb_e'(arb_mode);
        arb_win  = (arb_sel == ARB_PRIO) ? pr_win : rr_win;
        req_any  = arb_sel == ARB_PRIO ? pr_found : rr_found;
    end

    // Purpose: serving, waiting and burst-hold status of the current cycle.
    always_comb begin
        grant_vld = conn_on && req[conn_idx];
        wait_lat  = req_any && !grant_vld;
        hold      = grant_vld && burst_busy;
    end

    // Purpose: drive the one-hot grant bus from the registered connection.
    for (genvar g = 0; g < N_MST; g++) begin : g_grant
        assign grant[g] = conn_on && (conn_idx == IDX_W'(g));
    end

    // Purpose: connection register: hold, re-arbitrate or park.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_on  <= (park_e'(park_mode) == PARK_FIXED);
            conn_idx <= park_idx;
            rr_last  <= IDX_W'(N_MST - 1);
        end else if (hold) begin
            conn_on  <= conn_on;
        end else if (req_any) begin
            conn_on  <= 1'b1;
            conn_idx <= arb_win;
            rr_last  <= arb_win;
        end else begin
            case (park_sel)
                PARK_LAST:  conn_on <= conn_on;
                PARK_FIXED: begin
                    conn_on  <= 1'b1;
                    conn_idx <= park_idx;
                end
                default:    conn_on <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/slv_grant_arbiter_chk.sv
// Module: property checker for slv_grant_arbiter, bound to every instance.
// Assumes: the same parameters as the bound instance.
module slv_grant_arbiter_chk #(
    parameter int N_MST = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_MST-1:0]         req,
    input logic                     burst_busy,
    input logic [1:0]               park_mode,
    input logic [$clog2(N_MST)-1:0] park_idx,
    input logic [N_MST-1:0]         grant,
    input logic                     grant_vld,
    input logic                     wait_lat
);

    localparam logic [N_MST-1:0] ONE = {{(N_MST-1){1'b0}}, 1'b1};

    // R1: at most one master owns the slave
    a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: a waiting cycle is always followed by a connection
    a_r3_wait_then_grant: assert property (@(posedge clk) disable iff (!rst_n)
        wait_lat |=> (grant != '0));

    // R4: no change of owner inside a burst
    a_r4_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && burst_busy) |=> $stable(grant));

    // R7: no parking releases the slave after an idle cycle
    a_r7_park_none: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && (park_mode == 2'd0 || park_mode == 2'd3)) |=> (grant == '0));

    // R8: last-owner parking keeps the connection through idle cycles
    a_r8_park_last: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && park_mode == 2'd1) |=> $stable(grant));

    // R9: fixed parking returns to the programmed master
    a_r9_park_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && park_mode == 2'd2) |=> (grant == (ONE << $past(park_idx))));

endmodule

bind slv_grant_arbiter slv_grant_arbiter_chk #(.N_MST(N_MST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .burst_busy (burst_busy),
    .park_mode  (park_mode),
    .park_idx   (park_idx),
    .grant      (grant),
    .grant_vld  (grant_vld),
    .wait_lat   (wait_lat)
);

// File: tb/slv_grant_arbiter_test.sv
`timescale 1ns/1ps
// Bench: directed sweeps plus a random phase, each cycle judged by a
// reference model written from the requirements.
module slv_grant_arbiter_test;

    localparam int N  = 16;
    localparam int PW = 4;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic            burst_busy = 1'b0;
    logic            arb_mode = 1'b0;
    logic [1:0]      park_mode = 2'd0;
    logic [IW-1:0]   park_idx = '0;
    logic [N*PW-1:0] prio = '0;
    logic [N-1:0]    grant;
    logic            grant_vld;
    logic            wait_lat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit exp_on;
    int exp_idx;
    int exp_last;

    slv_grant_arbiter #(.N_MST(N), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .burst_busy(burst_busy),
        .arb_mode(arb_mode), .park_mode(park_mode), .park_idx(park_idx),
        .prio(prio), .grant(grant), .grant_vld(grant_vld), .wait_lat(wait_lat)
    );

    always #4 clk = ~clk;

    // rotating choice per R5
    function automatic int ref_rr(input logic [N-1:0] r, input int last);
        for (int k = 1; k <= N; k++)
            if (r[(last + k) % N]) return (last + k) % N;
        return -1;
    endfunction

    // priority choice per R6
    function automatic int ref_prio(input logic [N-1:0] r, input logic [N*PW-1:0] p);
        int best_i = -1;
        int best_v = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && int'(p[i*PW +: PW]) > best_v) begin
                best_v = int'(p[i*PW +: PW]);
                best_i = i;
            end
        return best_i;
    endfunction

    task automatic check(input bit ok, input string rq,
                         input logic [N+1:0] act, input logic [N+1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: {grant,vld,wait} actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // check the cycle's outputs, advance the model, move to the next negedge
    task automatic step(input string rq);
        logic [N-1:0] eg;
        bit evld, ewait;
        int w;
        #1;
        eg    = exp_on ? (N'(1) << exp_idx) : '0;
        evld  = exp_on && req[exp_idx];
        ewait = (req != '0) && !evld;
        check({grant, grant_vld, wait_lat} == {eg, evld, ewait}, rq,
              {grant, grant_vld, wait_lat}, {eg, evld, ewait});
        if (evld && burst_busy) begin
            // R4: owner held
        end else if (req != '0) begin
            w = arb_mode ? ref_prio(req, prio) : ref_rr(req, exp_last);
            exp_on = 1'b1; exp_idx = w; exp_last = w;   // R11: visible next cycle
        end else if (park_mode == 2'd2) begin
            exp_on = 1'b1; exp_idx = int'(park_idx);
        end else if (park_mode != 2'd1) begin
            exp_on = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input string rq);
        rst_n = 1'b0;
        req = '0;
        burst_busy = 1'b0;
        repeat (2) @(negedge clk);
        exp_on = (park_mode == 2'd2); exp_idx = int'(park_idx); exp_last = N - 1;
        rst_n = 1'b1;
        step(rq);
    endtask

    initial begin
        @(negedge clk);
        // R10: reset with fixed parking, then R2 zero-wait for the parked master
        park_mode = 2'd2; park_idx = IW'(5);
        do_reset("R10 fixed");
        req = N'(1) << 5;
        step("R2 parked master");
        park_mode = 2'd0;
        do_reset("R10 none");
        // R3 / R7 sweep of single requesters under no parking
        for (int i = 0; i < N; i++) begin
            req = N'(1) << i;
            step("R3 wait cycle");
            step("R3 granted");
            req = '0;
            step("R7 last cycle");
            step("R7 released");
        end
        // R5: all request, rotation with wrap
        req = '1;
        for (int i = 0; i < 40; i++) step("R5 rotate");
        req = 16'h8001;
        for (int i = 0; i < 6; i++) step("R5 wrap pair");
        // R8: last-owner parking
        park_mode = 2'd1;
        req = N'(1) << 4;
        repeat (2) step("R8 serve");
        req = '0;
        repeat (3) step("R8 parked");
        req = N'(1) << 4;
        step("R2 last owner");
        // R4: burst hold against a competitor
        req = N'(1) << 2; burst_busy = 1'b1;
        repeat (2) step("R4 owner");
        req = (N'(1) << 2) | (N'(1) << 7);
        repeat (5) step("R4 hold");
        burst_busy = 1'b0;
        repeat (3) step("R4 release");
        // R6: priority values, tie then raised
        arb_mode = 1'b1; prio = '0;
        req = (N'(1) << 3) | (N'(1) << 9);
        repeat (3) step("R6 tie");
        prio[9*PW +: PW] = 4'd7;
        repeat (3) step("R6 larger");
        // R9 fixed parking and R7 reserved code
        req = '0; park_mode = 2'd2; park_idx = IW'(11);
        repeat (3) step("R9 fixed park");
        park_mode = 2'd3;
        repeat (2) step("R7 reserved code");
        // random mix over all modes
        for (int c = 0; c < 4000; c++) begin
            if (c % 250 == 0) begin
                arb_mode  = 1'($urandom);
                park_mode = 2'($urandom);
                park_idx  = IW'($urandom);
                for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'($urandom % 3);
            end
            req = (($urandom % 4) == 0) ? '0 : (N'($urandom) & N'($urandom));
            burst_busy = 1'($urandom);
            step("R1/R5/R6 random");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule